// File: doc/BRIEF.md
# Dual-Buffered Pixel Hit Counter

This block sits behind one pixel's discriminator and counts hits with no dead time. It holds two tally registers. At any moment one of them counts while the other stays frozen with the total from the previous time window, ready to be shifted out. An external window line sets the boundaries of each counting interval. Every change of level on that line swaps the two roles: the counter that was idle is cleared and starts counting, and the counter that was counting freezes.

A serial port takes a snapshot of the frozen tally and streams it out one bit per clock, least significant bit first, followed by a sticky overflow flag. A run-time depth code sets the usable width of both counters. A counter that reaches its maximum holds that value and raises the overflow flag instead of wrapping. Readout runs in parallel with counting, so the window line can toggle at a rate of one swap every depth+2 clocks without losing a frame.

Top module: `dual_hit_counter`

## Requirements
- R1: After synchronous reset, counter 0 is the counting one, both tallies and flags are zero, `rd_valid_o` is low, and `rd_bit_o` is low whenever `rd_valid_o` is low.
- R2: Each clock with `hit_i` high and no swap adds one to the counting tally.
- R3: A swap happens in any clock where `window_i` differs from its value in the previous clock. The counting role moves to the other counter, and the counter that was counting is not changed by later hits until it is cleared again.
- R4: In a swap clock the newly counting tally is cleared to 0, or to 1 if `hit_i` is high in that same clock, and its overflow flag is cleared.
- R5: The effective depth D is `depth_i` clamped to the range 1..32, so code 0 gives 1 and codes above 32 give 32. A tally that already holds 2^D-1 keeps that value when more hits arrive.
- R6: A hit that arrives while the tally holds 2^D-1 sets that counter's overflow flag. The flag stays set until the counter is cleared by a swap.
- R7: A `rd_start_i` pulse while idle captures the frozen tally and D. Starting in the next clock, `rd_valid_o` is high for exactly D+1 clocks. `rd_bit_o` carries tally bits 0 through D-1 in that order, then the overflow flag.
- R8: A `rd_start_i` pulse while a readout is in progress has no effect on that readout.
- R9: Swaps and hits during a readout do not alter the bits being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the serial shift clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | One-clock hit pulse, already synchronised |
| window_i | input | 1 | Window line; each level change swaps the counters |
| depth_i | input | 6 | Depth code, clamped to 1..32 |
| rd_start_i | input | 1 | Starts a serial readout of the frozen tally |
| rd_bit_o | output | 1 | Serial data, LSB first, overflow flag last |
| rd_valid_o | output | 1 | High while `rd_bit_o` carries a readout bit |

## Verification
The bench builds the block at its full 32-bit width and drives depth codes 0, 4, 8 and 40. This covers both clamp limits, saturation within a few dozen hits, and the longest 33-bit stream. A reference model applies each window change, hit and start pulse. Its expected bit stream is queued into a scoreboard that the serial output drains. Swaps with coincident hits, restarts during a readout, and double swaps during a shift are all covered.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
    localparam int unsigned CNT_W = 32;
    localparam int unsigned DEP_W = $clog2(CNT_W + 1);
    localparam int unsigned SH_W  = CNT_W + 1;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [DEP_W-1:0] depth_t;

    typedef struct packed {
        count_t value;
        logic   ovf;
    } tally_t;

    function automatic depth_t clamp_depth(input depth_t d);
        if (d == '0) return depth_t'(1);
        if (int'(d) > int'(CNT_W)) return depth_t'(CNT_W);
        return d;
    endfunction

    function automatic count_t depth_mask(input depth_t d);
        count_t m;
        m = '0;
        for (int i = 0; i < int'(CNT_W); i++)
            if (i < int'(d)) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/dhc_tally.sv
module dhc_tally
    import dhc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr_i,
    input  logic   cnt_en_i,
    input  logic   hit_i,
    input  count_t limit_i,
    output tally_t tally_o
);
    tally_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (clr_i) begin
            q.value <= count_t'(hit_i);
            q.ovf   <= 1'b0;
        end else if (cnt_en_i && hit_i) begin
            if (q.value >= limit_i) q.ovf   <= 1'b1;
            else                    q.value <= q.value + 1'b1;
        end
    end

    assign tally_o = q;

    assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && cnt_en_i && hit_i && q.value >= limit_i) |=> ($stable(q.value) && q.ovf));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (q.ovf && !clr_i) |=> q.ovf);

    assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !cnt_en_i) |=> $stable(q));

    assert_swap_clear_R4: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (q.value == count_t'($past(hit_i)) && !q.ovf));
endmodule

// File: rtl/dhc_roles.sv
module dhc_roles (
    input  logic clk,
    input  logic rst,
    input  logic window_i,
    output logic act_o,
    output logic swap_o
);
    logic win_q;
    logic act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
            act_q <= 1'b0;
        end else begin
            win_q <= window_i;
            if (swap_o) act_q <= ~act_q;
        end
    end

    assign swap_o = window_i ^ win_q;
    assign act_o  = act_q;

    assert_swap_R3: assert property (@(posedge clk) disable iff (rst)
        swap_o |=> (act_o != $past(act_o)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !swap_o |=> $stable(act_o));
endmodule

// File: rtl/dhc_shifter.sv
module dhc_shifter
    import dhc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  tally_t snap_i,
    input  depth_t depth_i,
    output logic   bit_o,
    output logic   valid_o
);
    logic [SH_W-1:0] sh_q;
    logic [SH_W-1:0] load_vec;
    depth_t          left_q;

    always_comb begin
        load_vec = {1'b0, snap_i.value & depth_mask(depth_i)};
        load_vec[depth_i] = snap_i.ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (left_q != '0) begin
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 1'b1;
        end else if (start_i) begin
            sh_q   <= load_vec;
            left_q <= depth_i + 1'b1;
        end
    end

    assign valid_o = (left_q != '0);
    assign bit_o   = valid_o & sh_q[0];

    assert_start_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !valid_o) |=> valid_o);

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && start_i) |=> (left_q == $past(left_q) - 1'b1));

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> !bit_o);
endmodule

// File: rtl/dual_hit_counter.sv
module dual_hit_counter
    import dhc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             window_i,
    input  logic [DEP_W-1:0] depth_i,
    input  logic             rd_start_i,
    output logic             rd_bit_o,
    output logic             rd_valid_o
);
    logic   act;
    logic   swap;
    depth_t eff_depth;
    count_t limit;
    tally_t tallies [2];
    tally_t snap;
    logic [1:0] en_vec;

    assign eff_depth = clamp_depth(depth_i);
    assign limit     = depth_mask(eff_depth);

    dhc_roles u_roles (
        .clk      (clk),
        .rst      (rst),
        .window_i (window_i),
        .act_o    (act),
        .swap_o   (swap)
    );

    for (genvar g = 0; g < 2; g++) begin : g_tally
        assign en_vec[g] = !swap && (act == 1'(g));
        dhc_tally u_tally (
            .clk      (clk),
            .rst      (rst),
            .clr_i    (swap && (act != 1'(g))),
            .cnt_en_i (en_vec[g]),
            .hit_i    (hit_i),
            .limit_i  (limit),
            .tally_o  (tallies[g])
        );
    end

    assign snap = act ? tallies[0] : tallies[1];

    dhc_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .start_i (rd_start_i),
        .snap_i  (snap),
        .depth_i (eff_depth),
        .bit_o   (rd_bit_o),
        .valid_o (rd_valid_o)
    );

    assert_count_R2: assert property (@(posedge clk) disable iff (rst)
        (hit_i && !swap && !act && tallies[0].value < limit) |=>
            (tallies[0].value == $past(tallies[0].value) + 1'b1));
endmodule

// File: tb/dual_hit_counter_test.sv
module dual_hit_counter_test;
    import dhc_pkg::*;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   hit = 1'b0;
    logic   win = 1'b0;
    logic   start = 1'b0;
    depth_t dep = depth_t'(8);
    logic   rd_bit;
    logic   rd_valid;

    int vecs = 0;
    int bad  = 0;

    bit    exp_q[$];
    string tag_q[$];

    bit          m_act;
    logic [31:0] m_cnt [2];
    bit          m_ovf [2];
    bit          m_wq;
    int          m_left;

    always #2 clk = ~clk;

    dual_hit_counter uut (
        .clk        (clk),
        .rst        (rst),
        .hit_i      (hit),
        .window_i   (win),
        .depth_i    (dep),
        .rd_start_i (start),
        .rd_bit_o   (rd_bit),
        .rd_valid_o (rd_valid)
    );

    function automatic int eff(input int d);
        if (d == 0) return 1;
        if (d > 32) return 32;
        return d;
    endfunction

    task automatic cyc(input bit h, input bit w, input bit s, input string tag);
        int d;
        longint mx;
        int idle;
        @(negedge clk);
        hit = h; win = w; start = s;
        d  = eff(int'(dep));
        mx = (longint'(1) << d) - 1;
        if (m_left > 0) begin
            m_left--;
        end else if (s) begin
            idle = m_act ? 0 : 1;
            for (int i = 0; i < d; i++) begin
                exp_q.push_back(m_cnt[idle][i]);
                tag_q.push_back(tag);
            end
            exp_q.push_back(m_ovf[idle]);
            tag_q.push_back(tag);
            m_left = d + 1;
        end
        if (w != m_wq) begin
            m_cnt[m_act ? 0 : 1] = h ? 32'd1 : 32'd0;
            m_ovf[m_act ? 0 : 1] = 1'b0;
            m_act = ~m_act;
        end else if (h) begin
            if (longint'(m_cnt[m_act]) >= mx) m_ovf[m_act] = 1'b1;
            else m_cnt[m_act] = m_cnt[m_act] + 1;
        end
        m_wq = w;
    endtask

    task automatic drain();
        while (m_left > 0) cyc(1'b0, win, 1'b0, "");
        cyc(1'b0, win, 1'b0, "");
    endtask

    task automatic readout(input string tag);
        cyc(1'b0, win, 1'b1, tag);
        drain();
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                vecs++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R7: unexpected valid bit, got %0b expected no bit", rd_bit);
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rd_bit !== e) begin
                        bad++;
                        $display("FAIL %s: serial bit got %0b expected %0b", t, rd_bit, e);
                    end
                end
            end else if (rd_bit !== 1'b0) begin
                bad++;
                $display("FAIL R1: idle rd_bit got %0b expected 0", rd_bit);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        m_act = 0; m_cnt[0] = 0; m_cnt[1] = 0; m_ovf[0] = 0; m_ovf[1] = 0;
        m_wq = 0; m_left = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        vecs++;
        if (rd_valid !== 1'b0 || rd_bit !== 1'b0) begin
            bad++;
            $display("FAIL R1: reset outputs got %0b%0b expected 00", rd_valid, rd_bit);
        end
        // R1: idle counter 1 reads zero after reset
        readout("R1");

        // R2 count, R3 freeze while other counts
        repeat (5) cyc(1'b1, 1'b0, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b0, "");
        cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b1, "R3");
        cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b1, "R8");
        cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b1, "R8");
        drain();

        // R4: swap with coincident hit
        cyc(1'b1, 1'b0, 1'b0, "");
        readout("R2");
        cyc(1'b1, 1'b0, 1'b0, "");
        cyc(1'b1, 1'b0, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b0, "");
        readout("R4");

        // R5 saturation at depth 4, R6 overflow
        dep = depth_t'(4);
        cyc(1'b0, win, 1'b0, "");
        repeat (20) cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b0, 1'b0, "");
        readout("R5");
        cyc(1'b0, 1'b1, 1'b0, "");
        cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b0, 1'b0, "");
        readout("R6");

        // R5 clamp low: code 0 -> depth 1
        dep = depth_t'(0);
        cyc(1'b0, win, 1'b0, "");
        repeat (3) cyc(1'b1, 1'b0, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b0, "");
        readout("R5");

        // R5 clamp high: code 40 -> depth 32
        dep = depth_t'(40);
        cyc(1'b0, win, 1'b0, "");
        repeat (6) cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b0, 1'b0, "");
        readout("R5");

        // R9: swaps and hits during shift
        dep = depth_t'(8);
        cyc(1'b0, win, 1'b0, "");
        repeat (7) cyc(1'b1, 1'b0, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b1, 1'b0, 1'b0, "");
        cyc(1'b1, 1'b1, 1'b0, "");
        cyc(1'b1, 1'b1, 1'b0, "");
        drain();
        readout("R3");

        repeat (3) cyc(1'b0, win, 1'b0, "");
        vecs++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R7: %0d bits missing, expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule